// File: doc/BRIEF.md
# Dual-Channel High/Low Pulse Generator

This block produces two independent rectangular waveforms. Each channel spends a programmed number of scaled time units at logic one, then a second programmed number at logic zero, and repeats. The time unit comes from one of four tick strobes that run in the system clock domain. A per-channel divider of 1 to 128 stretches the selected strobe.

Software programs the block through a small 32-bit register port. Each channel has a count word that packs its high and low durations. One control word, shared by both channels, holds the run bits, the strobe selects, the divider settings and the divider gates. A change of counts made while a channel runs is held back until the current period ends. The waveform therefore never shows a mixed period. To invert the output, program the two counts the other way round.

Top module: `duo_pwm`

## Requirements
- R1: After reset every register reads zero and both outputs are low.
- R2: The count word of channel A is at byte offset 0x0 and that of channel B at 0x4. The control word is at 0x8. Offset 0xC reads zero. The count words read back what was written. The control word reads back what was written with bits 3:2 and 31:24 forced to zero, so writing all ones reads 0x00FFFFF3.
- R3: In a count word, bits 31:16 give the high duration H and bits 15:0 give the low duration L, both in scaled ticks. A running channel is high for H scaled ticks and then low for L, so one period lasts H+L scaled ticks.
- R4: Control bit 0 runs channel A and bit 1 runs channel B. A channel that is not running drives zero and restarts from the beginning of its high phase once it runs again.
- R5: Control bits 5:4 (channel A) and 7:6 (channel B) give the index k of the tick strobe tick_src[k] that is counted.
- R6: Control bits 14:8 (channel A) and 22:16 (channel B) hold a value D. One scaled tick occurs for every D+1 selected strobes.
- R7: Control bit 15 (channel A) and bit 23 (channel B) gate the divider. While the gate bit is clear, a running channel's position does not move and its output holds.
- R8: H=0 gives an output that stays low. L=0 with H>0 gives an output that stays high. No pulse appears in either case.
- R9: Counts written while a channel runs take effect only when the current period ends, at the start of the next high phase.
- R10: The two channels run independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_src | input | 4 | Four tick strobes, each high for one cycle per event |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 4 | Byte offset of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| pwm_out | output | 2 | Waveform outputs, bit 0 is channel A, bit 1 is channel B |

## Verification
The strobe inputs are driven with different rates: every cycle, every second, every third and every seventh cycle. A wrong select therefore changes the period visibly. Divider values 0 and 3 separate an off-by-one in the divide. Count pairs include asymmetric values and both zero cases, and high-cycle totals over whole periods catch swapped count fields. Changes made mid-period, a closed gate and restarting from stop are each compared cycle by cycle with a behavioural model. This shows whether new counts leak into a running period, whether a gated channel drifts, and whether a restart begins high.

// File: rtl/duo_pwm_pkg.sv
package duo_pwm_pkg;
  localparam int NUM_CH = 2;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 16;
  localparam int DIV_W  = 7;
  localparam int SRC_N  = 4;
  localparam int SEL_W  = $clog2(SRC_N);
  localparam int POS_W  = CNT_W + 1;

  // Bits of the control word that hold state; the others read zero.
  localparam logic [DATA_W-1:0] CTRL_KEEP = 32'h00FF_FFF3;

  function automatic int run_bit(input int ch);
    return ch;
  endfunction

  function automatic int sel_lsb(input int ch);
    return 4 + 2 * ch;
  endfunction

  function automatic int div_lsb(input int ch);
    return 8 + 8 * ch;
  endfunction

  function automatic int gate_bit(input int ch);
    return 15 + 8 * ch;
  endfunction

  // True when the position just completed is the last one of the period.
  function automatic logic period_last(input logic [POS_W-1:0] pos,
                                       input logic [CNT_W-1:0] hi,
                                       input logic [CNT_W-1:0] lo);
    logic [POS_W:0] next_pos;
    logic [POS_W:0] span;
    next_pos = {1'b0, pos} + 1'b1;
    span     = {2'b00, hi} + {2'b00, lo};
    return next_pos >= span;
  endfunction

  // Output is high while the position lies inside the high phase.
  function automatic logic in_high(input logic [POS_W-1:0] pos,
                                   input logic [CNT_W-1:0] hi);
    return {1'b0, hi} > pos;
  endfunction
endpackage

// File: rtl/duo_pwm_regs.sv
module duo_pwm_regs
  import duo_pwm_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [DATA_W-1:0]              wdata,
  output logic [DATA_W-1:0]              rdata,
  output logic [DATA_W-1:0]              ctrl,
  output logic [NUM_CH-1:0][DATA_W-1:0]  counts
);
  localparam logic [1:0] SLOT_CTRL = 2'd2;

  logic [1:0] slot;
  assign slot = addr[3:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      counts <= '0;
    end else if (wr) begin
      if (slot == SLOT_CTRL) ctrl <= wdata & CTRL_KEEP;
      for (int c = 0; c < NUM_CH; c++) begin
        if (slot == 2'(c)) counts[c] <= wdata;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (slot == SLOT_CTRL) rdata = ctrl;
    for (int c = 0; c < NUM_CH; c++) begin
      if (slot == 2'(c)) rdata = counts[c];
    end
  end
endmodule

// File: rtl/duo_pwm_prescale.sv
module duo_pwm_prescale
  import duo_pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [SRC_N-1:0] src,
  input  logic [SEL_W-1:0] sel,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] pcnt;
  logic             src_hit;
  logic             at_limit;

  assign src_hit  = src[sel];
  assign at_limit = (pcnt == div);
  assign tick     = active & src_hit & at_limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pcnt <= '0;
    else if (!active)    pcnt <= '0;
    else if (src_hit)    pcnt <= at_limit ? '0 : pcnt + 1'b1;
  end
endmodule

// File: rtl/duo_pwm_wave.sv
module duo_pwm_wave
  import duo_pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] hi_req,
  input  logic [CNT_W-1:0] lo_req,
  output logic             wave,
  output logic             wrap,
  output logic             hi_zero,
  output logic             lo_zero
);
  logic [POS_W-1:0] pos;
  logic [CNT_W-1:0] hi_cur;
  logic [CNT_W-1:0] lo_cur;
  logic             last;

  assign last    = period_last(pos, hi_cur, lo_cur);
  assign wrap    = run & tick & last;
  assign wave    = run & in_high(pos, hi_cur);
  assign hi_zero = (hi_cur == '0);
  assign lo_zero = (lo_cur == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos    <= '0;
      hi_cur <= '0;
      lo_cur <= '0;
    end else if (!run || wrap) begin
      pos    <= '0;
      hi_cur <= hi_req;
      lo_cur <= lo_req;
    end else if (tick) begin
      pos    <= pos + 1'b1;
    end
  end
endmodule

// File: rtl/duo_pwm.sv
module duo_pwm
  import duo_pwm_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_N-1:0]  tick_src,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [NUM_CH-1:0] pwm_out
);
  logic [DATA_W-1:0]             ctrl;
  logic [NUM_CH-1:0][DATA_W-1:0] counts;
  logic [NUM_CH-1:0]             chan_en;
  logic [NUM_CH-1:0]             gate_en;
  logic [NUM_CH-1:0]             ptick;
  logic [NUM_CH-1:0]             period_wrap;
  logic [NUM_CH-1:0]             hi_zero;
  logic [NUM_CH-1:0]             lo_zero;

  duo_pwm_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (reg_wr),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .rdata  (reg_rdata),
    .ctrl   (ctrl),
    .counts (counts)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    assign chan_en[ch] = ctrl[run_bit(ch)];
    assign gate_en[ch] = ctrl[gate_bit(ch)];

    duo_pwm_prescale u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (chan_en[ch] & gate_en[ch]),
      .src    (tick_src),
      .sel    (ctrl[sel_lsb(ch) +: SEL_W]),
      .div    (ctrl[div_lsb(ch) +: DIV_W]),
      .tick   (ptick[ch])
    );

    duo_pwm_wave u_wave (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (chan_en[ch]),
      .tick    (ptick[ch]),
      .hi_req  (counts[ch][DATA_W-1 -: CNT_W]),
      .lo_req  (counts[ch][CNT_W-1:0]),
      .wave    (pwm_out[ch]),
      .wrap    (period_wrap[ch]),
      .hi_zero (hi_zero[ch]),
      .lo_zero (lo_zero[ch])
    );
  end
endmodule

// File: rtl/duo_pwm_checker.sv
module duo_pwm_checker
  import duo_pwm_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] pwm_out,
  input logic [NUM_CH-1:0] chan_en,
  input logic [NUM_CH-1:0] ptick,
  input logic [NUM_CH-1:0] period_wrap,
  input logic [NUM_CH-1:0] hi_zero,
  input logic [NUM_CH-1:0] lo_zero
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
    AST_STOPPED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !chan_en[ch] |-> !pwm_out[ch]); // R4
    AST_TICK_ONLY_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
      ptick[ch] |-> chan_en[ch]); // R6
    AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      chan_en[ch] && !ptick[ch] |=> ($stable(pwm_out[ch]) || !chan_en[ch])); // R7
    AST_ZERO_HIGH_STAYS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      chan_en[ch] && hi_zero[ch] |-> !pwm_out[ch]); // R8
    AST_ZERO_LOW_STAYS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      chan_en[ch] && lo_zero[ch] && !hi_zero[ch] |-> pwm_out[ch]); // R8
    AST_WRAP_STARTS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      period_wrap[ch] && chan_en[ch] && !hi_zero[ch] |=> (pwm_out[ch] || !chan_en[ch] || hi_zero[ch])); // R9
  end
endmodule

bind duo_pwm duo_pwm_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pwm_out     (pwm_out),
  .chan_en     (chan_en),
  .ptick       (ptick),
  .period_wrap (period_wrap),
  .hi_zero     (hi_zero),
  .lo_zero     (lo_zero)
);

// File: tb/duo_pwm_bench.sv
`timescale 1ns/1ps
module duo_pwm_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  tick_src = '0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [1:0]  pwm_out;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  duo_pwm u_duo_pwm (
    .clk(clk), .rst_n(rst_n), .tick_src(tick_src), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pwm_out(pwm_out)
  );

  // Strobes at four different rates.
  always @(negedge clk) begin
    cyc <= cyc + 1;
    tick_src[0] <= 1'b1;
    tick_src[1] <= (cyc % 2) == 0;
    tick_src[2] <= (cyc % 3) == 0;
    tick_src[3] <= (cyc % 7) == 0;
  end

  // Behavioural reference, advanced on each rising edge.
  longint m_ctrl;
  longint m_cnt [2];
  int     m_pc [2];
  longint m_pos [2];
  longint m_hic [2];
  longint m_loc [2];

  function automatic bit m_out(int ch);
    bit run;
    run = ((m_ctrl >> ch) & 1) != 0;
    return run && (m_pos[ch] < m_hic[ch]);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 0;
      for (int c = 0; c < 2; c++) begin
        m_cnt[c] = 0; m_pc[c] = 0; m_pos[c] = 0; m_hic[c] = 0; m_loc[c] = 0;
      end
    end else begin
      for (int c = 0; c < 2; c++) begin
        bit run, gate, hit;
        int sel, dv;
        run  = ((m_ctrl >> c) & 1) != 0;
        gate = ((m_ctrl >> (15 + 8 * c)) & 1) != 0;
        sel  = int'((m_ctrl >> (4 + 2 * c)) & 3);
        dv   = int'((m_ctrl >> (8 + 8 * c)) & 127);
        hit  = tick_src[sel];
        if (!run) begin
          m_pos[c] = 0; m_pc[c] = 0;
          m_hic[c] = (m_cnt[c] >> 16) & 16'hFFFF;
          m_loc[c] = m_cnt[c] & 16'hFFFF;
        end else if (!gate) begin
          m_pc[c] = 0;
        end else if (hit) begin
          if (m_pc[c] == dv) begin
            m_pc[c] = 0;
            if (m_pos[c] + 1 >= m_hic[c] + m_loc[c]) begin
              m_pos[c] = 0;
              m_hic[c] = (m_cnt[c] >> 16) & 16'hFFFF;
              m_loc[c] = m_cnt[c] & 16'hFFFF;
            end else begin
              m_pos[c] = m_pos[c] + 1;
            end
          end else begin
            m_pc[c] = m_pc[c] + 1;
          end
        end
      end
      if (reg_wr) begin
        case (reg_addr[3:2])
          2'd0: m_cnt[0] = reg_wdata;
          2'd1: m_cnt[1] = reg_wdata;
          2'd2: m_ctrl = reg_wdata & 32'h00FF_FFF3;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // Every cycle: outputs against the model.
  always @(negedge clk) begin
    if (rst_n) begin
      for (int c = 0; c < 2; c++)
        chk(pwm_out[c] == m_out(c), cur_req, pwm_out[c], m_out(c));
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string req);
    reg_addr = a;
    #1;
    chk(reg_rdata == exp, req, reg_rdata, exp);
  endtask

  // Count high cycles of a channel over n cycles, starting now.
  task automatic measure(input int ch, input int n, input int exp, input string req);
    int highs = 0;
    for (int i = 0; i < n; i++) begin
      #1;
      if (pwm_out[ch]) highs++;
      @(negedge clk);
    end
    chk(highs == exp, req, highs, exp);
  endtask

  function automatic logic [31:0] ctl_a(int sel, int dv);
    return 32'h0000_8001 | 32'(sel << 4) | 32'(dv << 8);
  endfunction

  function automatic logic [31:0] ctl_b(int sel, int dv);
    return 32'h0080_0002 | 32'(sel << 6) | 32'(dv << 16);
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    rd(4'h0, 32'h0, "R1"); rd(4'h4, 32'h0, "R1"); rd(4'h8, 32'h0, "R1");
    chk(pwm_out == 2'b00, "R1", pwm_out, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: map and readback
    cur_req = "R2";
    wr(4'h0, 32'h1234_5678); wr(4'h4, 32'h9ABC_DEF0); wr(4'h8, 32'hFFFF_FFFF);
    rd(4'h0, 32'h1234_5678, "R2"); rd(4'h4, 32'h9ABC_DEF0, "R2");
    rd(4'h8, 32'h00FF_FFF3, "R2"); rd(4'hC, 32'h0, "R2");
    wr(4'h8, 32'h0);

    // R3: H=3 L=2, every-cycle strobe, no division -> 30 high in 50
    cur_req = "R3";
    wr(4'h0, 32'h0003_0002);
    wr(4'h8, ctl_a(0, 0));
    measure(0, 50, 30, "R3");
    wr(4'h8, 32'h0);

    // R6: divide by 4, H=1 L=1 -> period 8 cycles
    cur_req = "R6";
    wr(4'h0, 32'h0001_0001);
    wr(4'h8, ctl_a(0, 3));
    measure(0, 40, 20, "R6");
    wr(4'h8, 32'h0);

    // R5: strobe every third cycle, H=1 L=1 -> period 6 cycles
    cur_req = "R5";
    wr(4'h8, ctl_a(2, 0));
    repeat (5) @(negedge clk);
    measure(0, 60, 30, "R5");
    wr(4'h8, ctl_a(3, 1));
    repeat (60) @(negedge clk);
    wr(4'h8, 32'h0);

    // R8: zero durations
    cur_req = "R8";
    wr(4'h0, 32'h0000_0005);
    wr(4'h8, ctl_a(0, 0));
    measure(0, 30, 0, "R8");
    wr(4'h8, 32'h0);
    wr(4'h0, 32'h0005_0000);
    wr(4'h8, ctl_a(0, 0));
    measure(0, 30, 30, "R8");
    wr(4'h8, 32'h0);

    // R9: counts changed mid-period; model checks every cycle
    cur_req = "R9";
    wr(4'h0, 32'h0002_0003);
    wr(4'h8, ctl_a(0, 0));
    repeat (3) @(negedge clk);
    wr(4'h0, 32'h0006_0001);
    repeat (30) @(negedge clk);

    // R7: gate cleared while running -> output holds
    cur_req = "R7";
    wr(4'h8, 32'h0000_0001);
    begin
      logic held;
      #1 held = pwm_out[0];
      for (int i = 0; i < 20; i++) begin
        @(negedge clk); #1;
        chk(pwm_out[0] == held, "R7", pwm_out[0], held);
      end
    end
    wr(4'h8, ctl_a(0, 0));
    repeat (10) @(negedge clk);

    // R4: stop drives low, restart begins in the high phase
    cur_req = "R4";
    wr(4'h8, 32'h0);
    #1 chk(pwm_out[0] == 1'b0, "R4", pwm_out[0], 0);
    wr(4'h8, ctl_a(0, 0));
    #1 chk(pwm_out[0] == 1'b1, "R4", pwm_out[0], 1);
    wr(4'h8, 32'h0);

    // R10: both channels at once with different settings
    cur_req = "R10";
    wr(4'h0, 32'h0002_0005);
    wr(4'h4, 32'h0003_0001);
    wr(4'h8, ctl_a(0, 1) | ctl_b(1, 2));
    repeat (80) @(negedge clk);
    wr(4'h8, ctl_b(1, 2));
    #1 chk(pwm_out[0] == 1'b0, "R10", pwm_out[0], 0);
    repeat (40) @(negedge clk);

    finish_run();
  end
endmodule